// File: doc/BRIEF.md
# Double-Data-Rate Prefetch Data Serializer

This block sits between a memory controller's core and its data pins. On the write side it takes one word of twice the pin width per core clock. It drives the lower half on the pins while the clock is high and the upper half while the clock is low. Each byte lane has its own write-mask pin, and each mask bit moves with its beat. A per-lane data strobe comes from a quarter-phase-shifted clock, so each strobe edge falls in the middle of a beat. The strobe is driven for one cycle before the first beat and released after the last beat.

On the read side each byte lane has its own incoming strobe, which is assumed to be already shifted into the centre of the data eye. A lane's rising strobe edge captures the lower byte and its falling edge captures the upper byte. The core domain then delivers each completed double-width word with a one-cycle valid pulse. The controller frames each read burst with a window signal. A burst that ends on an odd number of strobe edges is reported as an error.

Top module: `ddr_serdes`

## Requirements
- R1: While reset is applied and in the first cycle after it, dqOe, dqsOe, wrTake, rdValid and rdOddErr are low.
- R2: A wrStart sampled while idle selects a burst length from wrBurst: 0 → 1 word (2 beats), 1 → 2 words (4 beats), 2 or 3 → 4 words (8 beats). wrTake is high for exactly that many consecutive cycles, starting in the cycle after wrStart.
- R3: dqsOe rises in the cycle after wrStart (the preamble cycle, in which dqOe is low). It stays high through the cycle of the last beat and falls in the cycle after. dqOe is high exactly in the cycles that follow a wrTake cycle.
- R4: The word on wrWord in a wrTake cycle is driven in the next cycle. Bits [N-1:0] appear on dqOut while clk is high and bits [2N-1:N] while clk is low, with N = LANE_W*LANES. Byte lane l is dqOut[8l+7:8l]. While dqOe is low, dqOut is zero.
- R5: During a beat cycle every dqsOut bit follows clk90: it rises a quarter period after the rising clk edge and falls a quarter period after the falling clk edge. Outside beat cycles dqsOut is low.
- R6: wrMask bit l drives dmOut[l] during the high half of the beat cycle, and bit LANES+l drives it during the low half. A set bit marks that byte as not to be written. dmOut is zero when no beat is driven.
- R7: A wrStart that arrives while a write burst is in progress is ignored: the running burst keeps its length and no new burst follows.
- R8: For each lane l, the rising edge of rdDqs[l] captures rdDq[8l+7:8l] into rdWord bits [8l+7:8l], and the following falling edge captures it into bits [N+8l+7:N+8l]. rdValid is high for one cycle, together with the new rdWord, starting at the first clk rising edge after the falling strobe edge.
- R9: A word completed while rdWindow is low at that clk edge is not delivered: rdValid stays low.
- R10: When rdWindow falls, rdOddErr pulses for the one cycle after the first clk edge that sees it low, if any lane had an odd number of strobe edges since rdWindow rose. Otherwise rdOddErr stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; beats are placed on both of its edges |
| clk90 | input | 1 | Same clock shifted by a quarter period; source of the write strobe |
| rst | input | 1 | Asynchronous reset, active high |
| wrStart | input | 1 | Request to begin a write burst |
| wrBurst | input | 2 | Burst length code for wrStart |
| wrWord | input | 2N | Write word supplied in a wrTake cycle |
| wrMask | input | 2*LANES | Per-beat, per-lane write mask for wrWord |
| wrTake | output | 1 | The block samples wrWord and wrMask at the end of this cycle |
| dqOut | output | N | Pin-side write data, two beats per clk |
| dqOe | output | 1 | Output enable for dqOut and dmOut |
| dmOut | output | LANES | Pin-side write mask, one bit per lane |
| dqsOut | output | LANES | Pin-side write strobe, one bit per lane |
| dqsOe | output | 1 | Output enable for dqsOut, including the preamble |
| rdDq | input | N | Pin-side read data |
| rdDqs | input | LANES | Centred read strobe, one bit per lane |
| rdWindow | input | 1 | High while a read burst is expected |
| rdWord | output | 2N | Reassembled read word |
| rdValid | output | 1 | One-cycle pulse per delivered rdWord |
| rdOddErr | output | 1 | One-cycle pulse for a burst with an odd number of strobe edges |

## Verification
Write results have fixed latencies. wrTake is due one cycle after wrStart, and dqsOe rises in that same cycle. The beats for a word appear one cycle after its take cycle. The bench samples the pins inside each half cycle, after clk90 has moved: at 1.5 ns for the rising beat, at 3.0 ns for the falling beat, and at 4.5 ns to see the strobe low again. Read words are due at the first clk rising edge after their falling strobe edge, and the error pulse comes one edge after the window closes. The bench therefore changes inputs only at 4.7 ns or in the first few hundred picoseconds after an edge, and reads read-side outputs 0.5 ns after the edge.

// File: rtl/ddr_serdes_pkg.sv
`timescale 1ns/1ps
package ddr_serdes_pkg;

  // Strobes from the write control to the datapath.
  typedef struct packed {
    logic take;      // sample the core word at the end of this cycle
    logic strobeOe;  // write strobe enabled (preamble plus beat cycles)
  } wrCtl_t;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_PRE  = 2'd1,
    WR_DATA = 2'd2
  } wrState_t;

  localparam int CNT_W = 3;

  // Number of core words moved by a burst code.
  function automatic logic [CNT_W-1:0] burstWords(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ddr_serdes_ctrl.sv
`timescale 1ns/1ps
module ddr_serdes_ctrl
  import ddr_serdes_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrStart,
  input  logic [1:0] wrBurst,
  output wrCtl_t     ctl
);

  wrState_t          state;
  logic [CNT_W-1:0]  wordsLeft;

  // Preamble cycle takes the first word; each beat cycle takes the next
  // word while any remain, and the cycle that empties the count is the
  // last beat.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state     <= WR_IDLE;
      wordsLeft <= '0;
    end else begin
      case (state)
        WR_IDLE: begin
          if (wrStart) begin
            state     <= WR_PRE;
            wordsLeft <= burstWords(wrBurst);
          end
        end
        WR_PRE: begin
          state     <= WR_DATA;
          wordsLeft <= wordsLeft - 3'd1;
        end
        WR_DATA: begin
          if (wordsLeft == '0) begin
            state <= WR_IDLE;
          end else begin
            wordsLeft <= wordsLeft - 3'd1;
          end
        end
        default: state <= WR_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.strobeOe = (state != WR_IDLE);
    ctl.take     = (state != WR_IDLE) && (wordsLeft != '0);
  end

endmodule

// File: rtl/ddr_serdes_dp.sv
`timescale 1ns/1ps
module ddr_serdes_dp
  import ddr_serdes_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    clk90,
  input  logic                    rst,
  input  wrCtl_t                  ctl,
  input  logic [2*LANE_W*LANES-1:0] wrWord,
  input  logic [2*LANES-1:0]      wrMask,
  output logic [LANE_W*LANES-1:0] dqOut,
  output logic                    dqOe,
  output logic [LANES-1:0]        dmOut,
  output logic [LANES-1:0]        dqsOut,
  output logic                    dqsOe,
  input  logic [LANE_W*LANES-1:0] rdDq,
  input  logic [LANES-1:0]        rdDqs,
  input  logic                    rdWindow,
  output logic [2*LANE_W*LANES-1:0] rdWord,
  output logic                    rdValid,
  output logic                    rdOddErr
);

  localparam int PIN_W  = LANE_W * LANES;
  localparam int WORD_W = 2 * PIN_W;

  // ---------------- write side ----------------
  logic [WORD_W-1:0]  beatWord;
  logic [2*LANES-1:0] beatMask;
  logic               beatLive;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      beatWord <= '0;
      beatMask <= '0;
      beatLive <= 1'b0;
    end else begin
      beatLive <= ctl.take;
      if (ctl.take) begin
        beatWord <= wrWord;
        beatMask <= wrMask;
      end
    end
  end

  // High half of clk carries the lower half of the word, low half the upper.
  always_comb begin
    dqOut = '0;
    dmOut = '0;
    if (beatLive) begin
      dqOut = clk ? beatWord[PIN_W-1:0] : beatWord[WORD_W-1:PIN_W];
      dmOut = clk ? beatMask[LANES-1:0] : beatMask[2*LANES-1:LANES];
    end
  end

  assign dqOe   = beatLive;
  assign dqsOe  = ctl.strobeOe;
  assign dqsOut = {LANES{beatLive & clk90}};

  // ---------------- read side ----------------
  logic [WORD_W-1:0] laneWord;
  logic [LANES-1:0]  laneImb;
  logic [LANES-1:0]  laneDone;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] riseByte;
    logic [LANE_W-1:0] holdLo;
    logic [LANE_W-1:0] holdHi;
    logic              posTog;
    logic              negTog;

    always_ff @(posedge rdDqs[l] or posedge rst) begin
      if (rst) begin
        riseByte <= '0;
        posTog   <= 1'b0;
      end else begin
        riseByte <= rdDq[l*LANE_W +: LANE_W];
        posTog   <= ~posTog;
      end
    end

    always_ff @(negedge rdDqs[l] or posedge rst) begin
      if (rst) begin
        holdLo <= '0;
        holdHi <= '0;
        negTog <= 1'b0;
      end else begin
        holdLo <= riseByte;
        holdHi <= rdDq[l*LANE_W +: LANE_W];
        negTog <= ~negTog;
      end
    end

    assign laneImb[l]  = posTog ^ negTog;
    assign laneDone[l] = negTog;
    assign laneWord[l*LANE_W +: LANE_W]         = holdLo;
    assign laneWord[PIN_W + l*LANE_W +: LANE_W] = holdHi;
  end

  logic             doneSeen;
  logic             winPrev;
  logic [LANES-1:0] imbBase;
  logic             newWord;

  assign newWord = laneDone[0] ^ doneSeen;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      doneSeen <= 1'b0;
      winPrev  <= 1'b0;
      imbBase  <= '0;
      rdWord   <= '0;
      rdValid  <= 1'b0;
      rdOddErr <= 1'b0;
    end else begin
      doneSeen <= laneDone[0];
      winPrev  <= rdWindow;
      rdValid  <= rdWindow && newWord;
      if (rdWindow && newWord) begin
        rdWord <= laneWord;
      end
      if (rdWindow && !winPrev) begin
        imbBase <= laneImb;
      end
      rdOddErr <= winPrev && !rdWindow && (|(laneImb ^ imbBase));
    end
  end

endmodule

// File: rtl/ddr_serdes.sv
`timescale 1ns/1ps
module ddr_serdes
  import ddr_serdes_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      clk90,
  input  logic                      rst,
  input  logic                      wrStart,
  input  logic [1:0]                wrBurst,
  input  logic [2*LANE_W*LANES-1:0] wrWord,
  input  logic [2*LANES-1:0]        wrMask,
  output logic                      wrTake,
  output logic [LANE_W*LANES-1:0]   dqOut,
  output logic                      dqOe,
  output logic [LANES-1:0]          dmOut,
  output logic [LANES-1:0]          dqsOut,
  output logic                      dqsOe,
  input  logic [LANE_W*LANES-1:0]   rdDq,
  input  logic [LANES-1:0]          rdDqs,
  input  logic                      rdWindow,
  output logic [2*LANE_W*LANES-1:0] rdWord,
  output logic                      rdValid,
  output logic                      rdOddErr
);

  wrCtl_t ctl;

  ddr_serdes_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrStart (wrStart),
    .wrBurst (wrBurst),
    .ctl     (ctl)
  );

  ddr_serdes_dp #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_dp (
    .clk      (clk),
    .clk90    (clk90),
    .rst      (rst),
    .ctl      (ctl),
    .wrWord   (wrWord),
    .wrMask   (wrMask),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .dmOut    (dmOut),
    .dqsOut   (dqsOut),
    .dqsOe    (dqsOe),
    .rdDq     (rdDq),
    .rdDqs    (rdDqs),
    .rdWindow (rdWindow),
    .rdWord   (rdWord),
    .rdValid  (rdValid),
    .rdOddErr (rdOddErr)
  );

  assign wrTake = ctl.take;

endmodule

// File: rtl/ddr_serdes_chk.sv
`timescale 1ns/1ps
module ddr_serdes_chk (
  input logic clk,
  input logic rst,
  input logic wrTake,
  input logic dqOe,
  input logic dqsOe,
  input logic rdWindow,
  input logic rdOddErr
);

  // R3
  data_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dqOe |-> dqsOe);

  // R3
  preamble_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dqsOe) |-> !dqOe);

  // R3
  postamble_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dqsOe) |-> $past(dqOe));

  // R2
  take_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    wrTake |-> dqsOe);

  // R10
  odd_err_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rdOddErr |-> (!$past(rdWindow) && $past(rdWindow, 2)));

endmodule

bind ddr_serdes ddr_serdes_chk chk (
  .clk      (clk),
  .rst      (rst),
  .wrTake   (wrTake),
  .dqOe     (dqOe),
  .dqsOe    (dqsOe),
  .rdWindow (rdWindow),
  .rdOddErr (rdOddErr)
);

// File: tb/ddr_serdes_test.sv
`timescale 1ns/1ps
module ddr_serdes_test;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int PIN_W  = LANE_W * LANES;
  localparam int WORD_W = 2 * PIN_W;
  localparam int MASK_W = 2 * LANES;

  logic              clk, clk90, rst;
  logic              wrStart;
  logic [1:0]        wrBurst;
  logic [WORD_W-1:0] wrWord;
  logic [MASK_W-1:0] wrMask;
  logic              wrTake;
  logic [PIN_W-1:0]  dqOut;
  logic              dqOe;
  logic [LANES-1:0]  dmOut;
  logic [LANES-1:0]  dqsOut;
  logic              dqsOe;
  logic [PIN_W-1:0]  rdDq;
  logic [LANES-1:0]  rdDqs;
  logic              rdWindow;
  logic [WORD_W-1:0] rdWord;
  logic              rdValid;
  logic              rdOddErr;

  int checks = 0;
  int fails  = 0;

  ddr_serdes #(.LANE_W(LANE_W), .LANES(LANES)) uut (
    .clk(clk), .clk90(clk90), .rst(rst),
    .wrStart(wrStart), .wrBurst(wrBurst), .wrWord(wrWord), .wrMask(wrMask),
    .wrTake(wrTake), .dqOut(dqOut), .dqOe(dqOe), .dmOut(dmOut),
    .dqsOut(dqsOut), .dqsOe(dqsOe), .rdDq(rdDq), .rdDqs(rdDqs),
    .rdWindow(rdWindow), .rdWord(rdWord), .rdValid(rdValid), .rdOddErr(rdOddErr)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    clk90 = 1'b0;
    #1.25;
    forever #2.5 clk90 = ~clk90;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int wordsFor(input logic [1:0] code);
    if (code == 2'd0) return 1;
    if (code == 2'd1) return 2;
    return 4;
  endfunction

  // Move to 4.7 ns into a cycle, the slot where inputs change.
  task automatic toSlot();
    @(posedge clk);
    #4.7;
  endtask

  task automatic doWrite(input logic [1:0] code, input logic pokeBusy);
    int nW = wordsFor(code);
    logic [WORD_W-1:0] w [4];
    logic [MASK_W-1:0] m [4];
    for (int i = 0; i < 4; i++) begin
      w[i] = {$urandom, $urandom};
      m[i] = MASK_W'($urandom);
    end
    toSlot();
    wrStart = 1'b1; wrBurst = code; wrWord = w[0]; wrMask = m[0];
    for (int c = 1; c <= nW + 2; c++) begin
      logic data;
      data = (c >= 2) && (c <= nW + 1);
      @(posedge clk);
      #0.1;
      wrStart = (c == 1) ? pokeBusy : 1'b0;   // R7: start during a burst
      if (c <= nW) begin wrWord = w[c-1]; wrMask = m[c-1]; end
      #1.4;
      chk("R2 wrTake", wrTake, (c <= nW));
      chk("R3 dqsOe", dqsOe, (c <= nW + 1));
      chk("R3 dqOe", dqOe, data);
      if (data) begin
        chk("R4 rising beat", dqOut, w[c-2][PIN_W-1:0]);
        chk("R6 rising mask", dmOut, m[c-2][LANES-1:0]);
        chk("R5 strobe high", dqsOut, {LANES{1'b1}});
      end else begin
        chk("R5 strobe idle", dqsOut, '0);
        chk("R4 idle data", dqOut, '0);
      end
      #1.5;
      if (data) begin
        chk("R4 falling beat", dqOut, w[c-2][WORD_W-1:PIN_W]);
        chk("R6 falling mask", dmOut, m[c-2][MASK_W-1:LANES]);
        chk("R5 strobe centred", dqsOut, {LANES{1'b1}});
      end else begin
        chk("R6 idle mask", dmOut, '0);
      end
      #1.5;
      chk("R5 strobe low", dqsOut, '0);
    end
  endtask

  task automatic doRead(input int nEdges);
    int nCyc = (nEdges + 1) / 2;
    logic [PIN_W-1:0] lo [5];
    logic [PIN_W-1:0] hi [5];
    for (int i = 0; i < 5; i++) begin
      lo[i] = PIN_W'($urandom);
      hi[i] = PIN_W'($urandom);
    end
    toSlot();
    rdWindow = 1'b1;
    for (int j = 0; j <= nCyc + 2; j++) begin
      logic expV;
      @(posedge clk);
      #0.2;
      if (j < nCyc) rdDq = lo[j];
      #0.3;
      expV = (j >= 1) && (2 * j <= nEdges);
      if (j >= nCyc + 1) chk("R9 no word outside window", rdValid, expV);
      else               chk("R8 rdValid", rdValid, expV);
      if (expV) chk("R8 rdWord", rdWord, {hi[j-1], lo[j-1]});
      if (j == nCyc + 1) chk("R10 odd burst flag", rdOddErr, nEdges % 2);
      else               chk("R10 no flag", rdOddErr, 1'b0);
      #0.75;
      if (2 * j < nEdges) rdDqs = '1;
      else if (j == nCyc + 1 && rdDqs != '0) rdDqs = '0;   // trailing edge, window closed
      #1.45;
      if (2 * j + 1 < nEdges) rdDq = hi[j];
      #1.05;
      if (2 * j + 1 < nEdges) rdDqs = '0;
      #0.95;
      if (j == nCyc) rdWindow = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wrStart = 1'b0; wrBurst = '0; wrWord = '0; wrMask = '0;
    rdDq = '0; rdDqs = '0; rdWindow = 1'b0;
    repeat (3) @(posedge clk);
    #1.0;
    chk("R1 dqOe", dqOe, 1'b0);
    chk("R1 dqsOe", dqsOe, 1'b0);
    chk("R1 wrTake", wrTake, 1'b0);
    chk("R1 rdValid", rdValid, 1'b0);
    chk("R1 rdOddErr", rdOddErr, 1'b0);
    #3.7;
    rst = 1'b0;
    @(posedge clk);
    #1.0;
    chk("R1 dqsOe after release", dqsOe, 1'b0);
    chk("R1 wrTake after release", wrTake, 1'b0);

    // Directed corners
    doWrite(2'd0, 1'b0);   // R2 shortest burst
    doWrite(2'd3, 1'b1);   // R2 code 3 as longest, R7 busy start
    doWrite(2'd1, 1'b1);
    doWrite(2'd2, 1'b0);
    doRead(8);             // R8 full burst
    doRead(3);             // R10 odd
    doRead(2);             // R10 clean after an odd burst
    doRead(1);             // R10 single edge
    doRead(4);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      if ($urandom % 2 == 0) doWrite(2'($urandom), 1'($urandom));
      else                   doRead(1 + int'($urandom % 9));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule